// File: doc/BRIEF.md
# Locked Write Sequence Monitor

This block watches the write side of an AXI3-style bus and polices locked write sequences. It sees each accepted write address, with its ID, address, lock code, cache and protection attributes, and each accepted write response. From these it keeps a count of writes still in flight and walks a small state machine through the life of a locked sequence. The sequence opens, runs, drains and closes with one unlocked write.

Rule breaches are reported on four error outputs. Advisory conditions are reported on three warning outputs. Each output is a one-cycle pulse that follows the clock edge at which the offending address was accepted. The monitor is meant to be dropped beside a bus master during simulation or emulation. It drives nothing back onto the bus. The current sequence phase is brought out so that a system bench can follow it.

Top module: `lockwr_mon`

## Requirements
- R1: After reset `seq_state` is 0 (idle) and every error and warning output is low.
- R2: A write address accepted in idle with `aw_lock` = 2'b10 opens a locked sequence and moves `seq_state` to 1 (locked).
- R3: `err_start` pulses when a sequence-opening locked address is accepted while any write is outstanding. A response accepted in that same cycle counts as completed.
- R4: `err_id` pulses when a locked address accepted in the locked phase carries an ID other than the one that opened the sequence.
- R5: An unlocked address accepted in the locked phase closes the sequence. If locked writes are still outstanding, `err_unlock` pulses and `seq_state` becomes 2 (drain-lock). Otherwise `seq_state` becomes 3 (drain-end) with no error.
- R6: Any write address accepted while `seq_state` is 2 or 3 pulses `err_end`. The state returns to 0 when the outstanding count reaches zero.
- R7: `warn_page` pulses when a locked address in the locked phase lies in a different 4 KB page (address bits 31..12) from the first one.
- R8: `warn_attr` pulses when a locked address in the locked phase has cache or protection attributes that differ from the first one.
- R9: `warn_len` pulses for the third and each later locked address of one sequence.
- R10: Each error and warning pulse is high for exactly the one cycle after the accepting edge. An address with `aw_valid` high and `aw_ready` low has no effect.
- R11: Lock codes 2'b00, 2'b01 and 2'b11 are treated as unlocked. Unlocked traffic in idle leaves `seq_state` at 0 and raises no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write transaction ID |
| aw_addr | input | ADDR_W | Write start address |
| aw_lock | input | 2 | Lock code, 2'b10 = locked |
| aw_cache | input | 4 | Cache attributes |
| aw_prot | input | 3 | Protection attributes |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| seq_state | output | 2 | 0 idle, 1 locked, 2 drain-lock, 3 drain-end |
| err_start | output | 1 | Locked sequence opened with writes outstanding |
| err_id | output | 1 | ID changed within the locked sequence |
| err_unlock | output | 1 | Unlocked write issued before locked writes completed |
| err_end | output | 1 | Address issued before the closing write completed |
| warn_page | output | 1 | Locked sequence left its 4 KB page |
| warn_attr | output | 1 | Cache or protection changed in the sequence |
| warn_len | output | 1 | Sequence exceeds two locked writes |

## Verification
A wrong outstanding count shows up at the ports at the next sequence boundary. It gives a false or missing `err_start` when a sequence opens, or a false `err_unlock` when one closes. A stuck drain state shows up as `seq_state` failing to return to 0 one cycle after the last response. Stale captured ID, page or attribute values show up as a missing or spurious `err_id`, `warn_page` or `warn_attr` pulse on the very next locked address. The tests therefore run complete sequences back to back, so that state left over from one sequence surfaces in the next.

// File: rtl/lockwr_mon.sv
module lockwr_mon #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [1:0]        aw_lock,
  input  logic [3:0]        aw_cache,
  input  logic [2:0]        aw_prot,
  input  logic              b_valid,
  input  logic              b_ready,
  output logic [1:0]        seq_state,
  output logic              err_start,
  output logic              err_id,
  output logic              err_unlock,
  output logic              err_end,
  output logic              warn_page,
  output logic              warn_attr,
  output logic              warn_len
);
  localparam int PG_W = ADDR_W - 12;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_LOCK = 2'd1, ST_DLCK = 2'd2, ST_DEND = 2'd3;

  logic [1:0]       st, st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx, pend;
  logic [ID_W-1:0]  id_q;
  logic [PG_W-1:0]  pg_q;
  logic [3:0]       cache_q;
  logic [2:0]       prot_q;
  logic [1:0]       len_q;

  wire aw_go  = aw_valid & aw_ready;
  wire b_go   = b_valid & b_ready & (cnt != '0);
  wire is_lk  = aw_lock == 2'b10;
  wire opn    = aw_go & is_lk & (st == ST_IDLE);
  wire more   = aw_go & is_lk & (st == ST_LOCK);
  wire cls    = aw_go & ~is_lk & (st == ST_LOCK);
  wire drain  = st[1];

  assign pend = cnt - CNT_W'(b_go);

  always_comb begin
    cnt_nx = pend;
    if (aw_go && pend != CNT_MAX) cnt_nx = pend + 1'b1;
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (opn) st_nx = ST_LOCK;
      ST_LOCK: if (cls) st_nx = (pend != '0) ? ST_DLCK : ST_DEND;
      default: if (cnt_nx == '0) st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      id_q    <= '0;
      pg_q    <= '0;
      cache_q <= '0;
      prot_q  <= '0;
      len_q   <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
      if (opn) begin
        id_q    <= aw_id;
        pg_q    <= aw_addr[ADDR_W-1:12];
        cache_q <= aw_cache;
        prot_q  <= aw_prot;
        len_q   <= 2'd1;
      end else if (more && len_q != 2'd3) begin
        len_q <= len_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_start  <= 1'b0;
      err_id     <= 1'b0;
      err_unlock <= 1'b0;
      err_end    <= 1'b0;
      warn_page  <= 1'b0;
      warn_attr  <= 1'b0;
      warn_len   <= 1'b0;
    end else begin
      err_start  <= opn & (pend != '0);
      err_id     <= more & (aw_id != id_q);
      err_unlock <= cls & (pend != '0);
      err_end    <= aw_go & drain;
      warn_page  <= more & (aw_addr[ADDR_W-1:12] != pg_q);
      warn_attr  <= more & ((aw_cache != cache_q) | (aw_prot != prot_q));
      warn_len   <= more & (len_q >= 2'd2);
    end
  end

  assign seq_state = st;
endmodule

// File: rtl/lockwr_mon_chk.sv
module lockwr_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       aw_valid,
  input logic       aw_ready,
  input logic [1:0] aw_lock,
  input logic [1:0] seq_state,
  input logic       err_start,
  input logic       err_id,
  input logic       err_unlock,
  input logic       err_end,
  input logic       warn_page,
  input logic       warn_attr,
  input logic       warn_len
);
  wire acc  = aw_valid & aw_ready;
  wire any  = err_start | err_id | err_unlock | err_end | warn_page | warn_attr | warn_len;

  AST_FLAG_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> $past(acc)); // R10
  AST_ERRORS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_start, err_id, err_unlock, err_end})); // R5
  AST_OPEN_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd1 && $past(seq_state) == 2'd0) |-> $past(acc && aw_lock == 2'b10)); // R2
  AST_IDLE_EXIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_state) == 2'd0 && seq_state != 2'd0) |-> seq_state == 2'd1); // R11
  AST_CLOSE_ON_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_state) == 2'd1 && seq_state[1]) |-> $past(acc && aw_lock != 2'b10)); // R5
  AST_END_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    err_end |-> $past(seq_state[1])); // R6
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_start |-> $past(seq_state) == 2'd0); // R3
  AST_ID_IN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    err_id |-> $past(seq_state) == 2'd1); // R4
endmodule

bind lockwr_mon lockwr_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
  .aw_lock(aw_lock), .seq_state(seq_state), .err_start(err_start),
  .err_id(err_id), .err_unlock(err_unlock), .err_end(err_end),
  .warn_page(warn_page), .warn_attr(warn_attr), .warn_len(warn_len)
);

// File: tb/lockwr_mon_tb.sv
module lockwr_mon_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aw_valid = 1'b0, aw_ready = 1'b0;
  logic [3:0]  aw_id = '0;
  logic [31:0] aw_addr = '0;
  logic [1:0]  aw_lock = '0;
  logic [3:0]  aw_cache = '0;
  logic [2:0]  aw_prot = '0;
  logic        b_valid = 1'b0, b_ready = 1'b0;
  logic [1:0]  seq_state;
  logic err_start, err_id, err_unlock, err_end, warn_page, warn_attr, warn_len;

  int checks = 0;
  int fails = 0;
  logic [6:0] fl;

  always #(PERIOD/2) clk = ~clk;

  lockwr_mon u_dut (
    .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .aw_id(aw_id), .aw_addr(aw_addr), .aw_lock(aw_lock), .aw_cache(aw_cache),
    .aw_prot(aw_prot), .b_valid(b_valid), .b_ready(b_ready), .seq_state(seq_state),
    .err_start(err_start), .err_id(err_id), .err_unlock(err_unlock), .err_end(err_end),
    .warn_page(warn_page), .warn_attr(warn_attr), .warn_len(warn_len)
  );

  // flag vector: {warn_len, warn_attr, warn_page, err_end, err_unlock, err_id, err_start}
  function automatic logic [6:0] flags();
    return {warn_len, warn_attr, warn_page, err_end, err_unlock, err_id, err_start};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic aw(input logic [3:0] id, input logic [31:0] a, input logic [1:0] lk,
                    input logic [3:0] c, input logic [2:0] p, input logic with_b = 1'b0);
    @(negedge clk);
    aw_valid = 1'b1; aw_ready = 1'b1; aw_id = id; aw_addr = a;
    aw_lock = lk; aw_cache = c; aw_prot = p;
    b_valid = with_b; b_ready = with_b;
    @(negedge clk);
    fl = flags();
    aw_valid = 1'b0; aw_ready = 1'b0; b_valid = 1'b0; b_ready = 1'b0;
  endtask

  task automatic bresp();
    @(negedge clk);
    b_valid = 1'b1; b_ready = 1'b1;
    @(negedge clk);
    b_valid = 1'b0; b_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", 32'(seq_state), 0);
    chk("R1 flags", 32'(flags()), 0);
  endtask

  task automatic t_clean();
    aw(4'd3, 32'h1000, 2'b10, 4'h3, 3'd0);
    chk("R2 open flags", 32'(fl), 0);
    chk("R2 open state", 32'(seq_state), 1);
    aw(4'd3, 32'h1040, 2'b10, 4'h3, 3'd0);
    chk("R4 same id", 32'(fl), 0);
    bresp(); bresp();
    aw(4'd3, 32'h5000, 2'b00, 4'h0, 3'd1);
    chk("R5 clean close flags", 32'(fl), 0);
    chk("R5 clean close state", 32'(seq_state), 3);
    bresp();
    chk("R6 back idle", 32'(seq_state), 0);
    @(negedge clk);
    chk("R10 one cycle", 32'(flags()), 0);
  endtask

  task automatic t_start_err();
    aw(4'd1, 32'h200, 2'b00, 4'h0, 3'd0);
    chk("R11 unlocked idle", 32'(fl), 0);
    chk("R11 stays idle", 32'(seq_state), 0);
    aw(4'd1, 32'h300, 2'b10, 4'h0, 3'd0);
    chk("R3 start err", 32'(fl), 7'b0000001);
    @(negedge clk);
    chk("R10 pulse clears", 32'(flags()), 0);
    bresp(); bresp();
    aw(4'd1, 32'h400, 2'b00, 4'h0, 3'd0);
    chk("R5 drained close", 32'(seq_state), 3);
    bresp();
  endtask

  task automatic t_same_cycle();
    aw(4'd2, 32'h10, 2'b01, 4'h0, 3'd0);
    chk("R11 code 01 unlocked", 32'(seq_state), 0);
    aw(4'd2, 32'h20, 2'b10, 4'h0, 3'd0, 1'b1);
    chk("R3 completion same cycle", 32'(fl), 0);
    chk("R2 opened", 32'(seq_state), 1);
    bresp();
    aw(4'd2, 32'h30, 2'b11, 4'h0, 3'd0);
    chk("R11 code 11 closes", 32'(seq_state), 3);
    bresp();
  endtask

  task automatic t_id_and_early();
    aw(4'd5, 32'h8000, 2'b10, 4'h2, 3'd2);
    // valid without ready: different id, must have no effect
    @(negedge clk);
    aw_valid = 1'b1; aw_id = 4'd9; aw_lock = 2'b10; aw_addr = 32'h9000;
    @(negedge clk);
    chk("R10 no ready ignored", 32'(flags()), 0);
    aw_valid = 1'b0;
    aw(4'd6, 32'h8010, 2'b10, 4'h2, 3'd2);
    chk("R4 id change", 32'(fl), 7'b0000010);
    aw(4'd5, 32'h8020, 2'b00, 4'h0, 3'd0);
    chk("R5 early unlock", 32'(fl), 7'b0000100);
    chk("R5 drain-lock state", 32'(seq_state), 2);
    aw(4'd5, 32'h8030, 2'b00, 4'h0, 3'd0);
    chk("R6 addr during drain", 32'(fl), 7'b0001000);
    bresp(); bresp(); bresp();
    chk("R6 not yet idle", 32'(seq_state), 2);
    bresp();
    chk("R6 idle after drain", 32'(seq_state), 0);
  endtask

  task automatic t_warn();
    aw(4'd7, 32'h1000, 2'b10, 4'h3, 3'd1);
    aw(4'd7, 32'h2010, 2'b10, 4'h3, 3'd1);
    chk("R7 page change", 32'(fl), 7'b0010000);
    aw(4'd7, 32'h1020, 2'b10, 4'hF, 3'd1);
    chk("R8 R9 attr and length", 32'(fl), 7'b1100000);
    aw(4'd7, 32'h1030, 2'b10, 4'h3, 3'd0);
    chk("R8 prot change R9 fourth", 32'(fl), 7'b1100000);
    bresp(); bresp(); bresp(); bresp();
    aw(4'd7, 32'h1040, 2'b00, 4'h0, 3'd0);
    aw(4'd7, 32'h1050, 2'b00, 4'h0, 3'd0);
    chk("R6 addr during drain-end", 32'(fl), 7'b0001000);
    bresp(); bresp();
    chk("R6 idle", 32'(seq_state), 0);
    aw(4'd1, 32'h0, 2'b10, 4'h0, 3'd0);
    aw(4'd1, 32'h4, 2'b10, 4'h0, 3'd0);
    chk("R9 count restarts", 32'(fl), 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_start_err();
    t_same_cycle();
    t_id_and_early();
    t_warn();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule